// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

An 8-bit up-counter advances by one on every clock cycle in which the tick input is high and the timer is enabled. It runs in one of two modes. In interval mode, each wrap from 0xFF to 0x00 sets a sticky flag, and that flag is the interrupt request. The counter keeps counting after each wrap, so the interrupt recurs at a fixed period.

In watchdog mode, software is expected to rewrite the counter before it wraps. If the counter does wrap, the block sets a watchdog flag and sends out an overflow pulse of fixed length. If reset generation is enabled, it also drives a chip-level reset pulse of fixed length.

Software reaches three registers through a simple write port and a registered read port: control/status, reset control/status, and the counter itself. The synchronous external reset takes priority over every other event in the block.

Top module: `dual_watchdog_timer`

## Requirements
- R1: After the external reset, all three registers read 0x00 and `irq`, `ovf_out` and `int_rst` are low. A read returns the selected register one cycle after `rd_sel` is applied. Select codes: 0 is control/status, 1 is the counter, 2 is reset control/status, and 3 reads as 0x00.
- R2: Control/status bit 5 is the enable bit. When it is 1, each cycle with `tick` high increments the counter by one. When it is 0, ticks leave the counter unchanged. A write to select 1 loads the counter directly.
- R3: Control/status bit 6 selects the mode: 0 is interval, 1 is watchdog. In interval mode, a wrap from 0xFF to 0x00 sets control/status bit 7, and `irq` goes high in that same cycle. The counter keeps running after the wrap.
- R4: Control/status bit 7 stays set until software writes 0 to it. Writing 1 to it has no effect. If a wrap and a software clear happen in the same cycle, the wrap wins and the flag stays set.
- R5: In watchdog mode, a wrap sets reset control/status bit 7 and does not raise `irq`. Writing 0 to that bit clears it.
- R6: A watchdog-mode wrap starts an `ovf_out` pulse. The pulse is 132 cycles long when reset-enable (reset control/status bit 6) is 1, and 130 cycles long when it is 0.
- R7: A watchdog-mode wrap with reset-enable at 1 drives `int_rst` high for exactly 518 cycles. With reset-enable at 0, `int_rst` stays low.
- R8: A counter write in the cycle of a pending wrap takes the written value and suppresses that overflow. A counter that is rewritten before it reaches the wrap never overflows.
- R9: If the external reset arrives in the same cycle as a watchdog wrap, the reset wins. The watchdog flag reads 0, and neither pulse starts.
- R10: The external reset ends any `ovf_out` or `int_rst` pulse that is in progress. `int_rst` itself does not act on the block's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External synchronous reset, active high |
| tick | input | 1 | Count enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Interval interrupt request |
| ovf_out | output | 1 | Watchdog overflow pulse |
| int_rst | output | 1 | Chip-level reset pulse |

## Verification
The hardest cases to reach are the same-cycle collisions: a wrap that meets a software clear of the flag, a wrap that meets a counter write, and a wrap that meets the external reset. Each depends on a single-cycle overlap at the 0xFF boundary. To reach them, the bench preloads the counter with 0xFF, then raises `tick` on the same falling edge that it applies the colliding write or reset, so both land on the one rising edge where the wrap would occur. The long pulses are measured by counting high cycles from that edge.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  typedef enum logic [1:0] {
    SEL_CSR  = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_RCSR = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CSR_FLAG_BIT   = 7;
  localparam int CSR_MODE_BIT   = 6;
  localparam int CSR_EN_BIT     = 5;
  localparam int RCSR_FLAG_BIT  = 7;
  localparam int RCSR_RSTEN_BIT = 6;
endpackage

// File: rtl/dwt_counter.sv
module dwt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  // A load takes priority over counting, so it cancels a wrap in the same cycle.
  assign wrap = run && !load && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (run)  cnt <= cnt + 1'b1;
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(load_val));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/dwt_pulse.sv
module dwt_pulse #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             out
);
  logic [LEN_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      out <= 1'b0;
    end else if (start) begin
      rem <= len - 1'b1;
      out <= 1'b1;
    end else if (rem != '0) begin
      rem <= rem - 1'b1;
    end else begin
      out <= 1'b0;
    end
  end

  assert_start_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> out);
  assert_end_R6: assert property (@(posedge clk) disable iff (rst)
    (out && !start && rem == '0) |=> !out);
endmodule

// File: rtl/dual_watchdog_timer.sv
module dual_watchdog_timer #(
  parameter int CNT_W       = 8,
  parameter int RST_LEN     = 518,
  parameter int OVF_LEN_RE  = 132,
  parameter int OVF_LEN_NRE = 130
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq,
  output logic             ovf_out,
  output logic             int_rst
);
  import dwt_pkg::*;

  localparam int OVF_MAX = (OVF_LEN_RE > OVF_LEN_NRE) ? OVF_LEN_RE : OVF_LEN_NRE;
  localparam int MAX_LEN = (RST_LEN > OVF_MAX) ? RST_LEN : OVF_MAX;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic iv_flag_q, mode_q, en_q, wd_flag_q, rst_en_q;
  logic [CNT_W-1:0] cnt;
  logic wrap, iv_set, wd_set, cnt_load;
  logic wr_csr, wr_rcsr;
  logic [LEN_W-1:0] ovf_len;

  assign wr_csr   = wr_en && (wr_sel == SEL_CSR);
  assign wr_rcsr  = wr_en && (wr_sel == SEL_RCSR);
  assign cnt_load = wr_en && (wr_sel == SEL_CNT);

  dwt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(en_q && tick), .load(cnt_load),
    .load_val(wr_data), .cnt(cnt), .wrap(wrap)
  );

  assign iv_set = wrap && !mode_q;
  assign wd_set = wrap && mode_q;

  // Control/status: the wrap beats a software clear of the flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      iv_flag_q <= 1'b0;
      mode_q    <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      if (iv_set)                                iv_flag_q <= 1'b1;
      else if (wr_csr && !wr_data[CSR_FLAG_BIT]) iv_flag_q <= 1'b0;
      if (wr_csr) begin
        mode_q <= wr_data[CSR_MODE_BIT];
        en_q   <= wr_data[CSR_EN_BIT];
      end
    end
  end

  // Reset control/status.
  always_ff @(posedge clk) begin
    if (rst) begin
      wd_flag_q <= 1'b0;
      rst_en_q  <= 1'b0;
    end else begin
      if (wd_set)                                  wd_flag_q <= 1'b1;
      else if (wr_rcsr && !wr_data[RCSR_FLAG_BIT]) wd_flag_q <= 1'b0;
      if (wr_rcsr) rst_en_q <= wr_data[RCSR_RSTEN_BIT];
    end
  end

  assign irq     = iv_flag_q;
  assign ovf_len = rst_en_q ? LEN_W'(OVF_LEN_RE) : LEN_W'(OVF_LEN_NRE);

  dwt_pulse #(.LEN_W(LEN_W)) u_ovf_pulse (
    .clk(clk), .rst(rst), .start(wd_set), .len(ovf_len), .out(ovf_out)
  );

  dwt_pulse #(.LEN_W(LEN_W)) u_rst_pulse (
    .clk(clk), .rst(rst), .start(wd_set && rst_en_q),
    .len(LEN_W'(RST_LEN)), .out(int_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      case (rd_sel)
        SEL_CSR: begin
          rd_data[CSR_FLAG_BIT] <= iv_flag_q;
          rd_data[CSR_MODE_BIT] <= mode_q;
          rd_data[CSR_EN_BIT]   <= en_q;
        end
        SEL_CNT: rd_data <= cnt;
        SEL_RCSR: begin
          rd_data[RCSR_FLAG_BIT]  <= wd_flag_q;
          rd_data[RCSR_RSTEN_BIT] <= rst_en_q;
        end
        default: rd_data <= '0;
      endcase
    end
  end

  assert_ivirq_R3: assert property (@(posedge clk) disable iff (rst)
    iv_set |=> irq);
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (!iv_set && wr_csr && !wr_data[CSR_FLAG_BIT]) |=> !irq);
  assert_wdflag_R5: assert property (@(posedge clk) disable iff (rst)
    wd_set |=> wd_flag_q);
  assert_wdnoirq_R5: assert property (@(posedge clk) disable iff (rst)
    (wd_set && !irq) |=> !irq);
  assert_rstgate_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(int_rst) |-> $past(rst_en_q));
  assert_suppress_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_out) |-> !$past(cnt_load));
  assert_abort_R10: assert property (@(posedge clk)
    rst |=> (!ovf_out && !int_rst && !irq));
endmodule

// File: tb/dual_watchdog_timer_tb.sv
module dual_watchdog_timer_tb;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0, rd_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq, ovf_out, int_rst;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_watchdog_timer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq(irq), .ovf_out(ovf_out), .int_rst(int_rst)
  );

  typedef struct packed {
    logic [7:0]  pre;
    logic [15:0] ticks;
    logic [7:0]  cnt;
    logic        flag;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h00, 16'd5,   8'h05, 1'b0},
    '{8'hFE, 16'd1,   8'hFF, 1'b0},
    '{8'hFF, 16'd1,   8'h00, 1'b1},
    '{8'hF0, 16'd20,  8'h04, 1'b1},
    '{8'h80, 16'd0,   8'h80, 1'b0},
    '{8'hFD, 16'd259, 8'h00, 1'b1}
  };

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] v);
    @(negedge clk); rd_sel = s;
    @(negedge clk); v = rd_data;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic measure(output int n_o, output int n_r);
    n_o = 0; n_r = 0;
    for (int i = 0; i < 1000; i++) begin
      if (ovf_out) n_o++;
      if (int_rst) n_r++;
      if (!ovf_out && !int_rst) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    int n_o, n_r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, v); check("R1 csr", v, 0);
    rd(2'd1, v); check("R1 cnt", v, 0);
    rd(2'd2, v); check("R1 rcsr", v, 0);
    check("R1 outputs", {irq, ovf_out, int_rst}, 0);

    // R2 disabled counter ignores ticks
    wr(2'd0, 8'h00); wr(2'd1, 8'h10); ticks(5);
    rd(2'd1, v); check("R2 disabled", v, 8'h10);

    // R2 R3 table: interval mode, enabled
    foreach (VECS[i]) begin
      wr(2'd0, 8'h20); wr(2'd1, VECS[i].pre); ticks(int'(VECS[i].ticks));
      rd(2'd1, v); check($sformatf("R2 R3 vec%0d cnt", i), v, VECS[i].cnt);
      rd(2'd0, v); check($sformatf("R3 vec%0d flag", i), v[7], VECS[i].flag);
      check($sformatf("R3 vec%0d irq", i), irq, VECS[i].flag);
    end

    // R4 writing 1 keeps the flag, writing 0 clears it
    wr(2'd0, 8'hA0); check("R4 write1 keeps", irq, 1);
    wr(2'd0, 8'h20); check("R4 clear", irq, 0);

    // R4 set beats clear in the same cycle
    wr(2'd1, 8'hFF);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h20;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check("R4 set wins", irq, 1);
    wr(2'd0, 8'h20);

    // R5 R6 R7 watchdog with reset enabled
    wr(2'd2, 8'h40); wr(2'd0, 8'h60); wr(2'd1, 8'hFF);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    measure(n_o, n_r);
    check("R6 ovf len re=1", n_o, 132);
    check("R7 rst len re=1", n_r, 518);
    check("R5 no irq", irq, 0);
    rd(2'd2, v); check("R5 wd flag", v, 8'hC0);

    // R6 R7 watchdog with reset disabled (write also clears flag, R5)
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R5 wd clear", v, 8'h00);
    wr(2'd1, 8'hFF);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    measure(n_o, n_r);
    check("R6 ovf len re=0", n_o, 130);
    check("R7 no rst re=0", n_r, 0);
    wr(2'd2, 8'h40);

    // R8 counter write in the wrap cycle suppresses overflow
    wr(2'd1, 8'hFF);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h00;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check("R8 no ovf", ovf_out, 0);
    rd(2'd2, v); check("R8 no flag", v, 8'h40);
    rd(2'd1, v); check("R8 cnt", v, 8'h00);

    // R8 serviced in time never overflows
    for (int k = 0; k < 4; k++) begin
      ticks(200); wr(2'd1, 8'h00);
    end
    check("R8 serviced", ovf_out, 0);
    rd(2'd2, v); check("R8 serviced flag", v, 8'h40);

    // R9 external reset coincident with wrap
    wr(2'd1, 8'hFF);
    @(negedge clk); tick = 1'b1; rst = 1'b1;
    @(negedge clk); tick = 1'b0; rst = 1'b0;
    check("R9 no pulses", {ovf_out, int_rst}, 0);
    rd(2'd2, v); check("R9 wd flag", v, 0);

    // R10 reset aborts pulses in progress
    wr(2'd2, 8'h40); wr(2'd0, 8'h60); wr(2'd1, 8'hFF);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 pulses running", {ovf_out, int_rst}, 3);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R10 aborted", {ovf_out, int_rst}, 0);
    repeat (5) @(negedge clk);
    check("R10 stay low", {ovf_out, int_rst}, 0);
    rd(2'd0, v); check("R10 csr cleared", v, 0);

    summary();
  end
endmodule